// File: doc/BRIEF.md
# Dual-Channel Compare Timer on a Shared Counter

This block is a timer peripheral built around a single prescaled up counter. The counter runs freely from zero to a programmable wrap value. Two compare channels watch it at the same time, and neither channel ever touches the counter or its wrap value. The first channel is a one-shot scheduler. Software writes a delay, and the block raises a single event once the counter has moved that many ticks past its value at the moment of the write. The compare point wraps modulo the counter period.

The second channel drives an output pin in toggle mode. At each compare match it inverts the pin, and hardware adds a programmed half-period step to its own compare value, again modulo the counter period. A square wave therefore runs without any software service while the counter keeps its full range for long one-shot delays. For example, a 1 ms tick with a step of 8 gives a period of 16 ms, or about 62 Hz.

Registers are reached through a simple single-cycle write strobe and a combinational read port. Both use the same 3-bit register select.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count reads 0, the wrap value reads all ones (0xFFFF), the prescaler reads 0, the status register reads 0, the pin is low and neither event output pulses.
- R2: While the run bit (control bit 0) is 1, the counter advances exactly once in every window of prescaler+1 consecutive clocks. Select 1 holds the prescaler.
- R3: On each advance the count rises by one. A count equal to or above the wrap value (select 2) returns to 0 instead. While the run bit is 0 the count holds.
- R4: Writing a delay n (select 3, with n not above the wrap value) sets the one-shot target to (count at that clock + n) mod (wrap+1). The one-shot event output pulses for one clock, in the same clock in which the count first takes the target value.
- R5: After firing, the one-shot channel is disarmed and gives no further events, even across counter wraps, until a new delay is written. A new write arms it again.
- R6: With toggle enable (control bit 1) set, each time the count takes the toggle compare value (select 4), the pin inverts and the toggle event pulses for one clock. The compare value then advances by the step (select 5), modulo wrap+1.
- R7: While toggle enable is 0, the pin equals the initial level (control bit 2) and no toggle events occur. A compare value written while the channel is disabled is the first match point after enable.
- R8: Status bit 0 (one-shot) and bit 1 (toggle) become 1 after the matching event and stay set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Select 7 reads the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register |
| os_evt | output | 1 | One-shot event pulse |
| tg_evt | output | 1 | Toggle match pulse |
| tg_pin | output | 1 | Square-wave output |

## Verification
The hardest case to reach is a one-shot delay whose target lies beyond the wrap value. The event must then land at a precise count after the counter has wrapped, and that count depends on the live count in the exact write clock. The bench therefore halts the counter with the run bit and reads the frozen count. It then writes the delay, restarts the counter, and predicts the target and the event clock without any uncertainty about phase. A small wrap value brings the toggle channel's modulo advance and the one-shot wrap within a few dozen clocks.

// File: rtl/timer_pkg.sv
// Shared register selects and control/status bit positions for the dual compare timer.
package timer_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_PSC    = 3'd1,
        SEL_RELOAD = 3'd2,
        SEL_DELAY  = 3'd3,
        SEL_CMP2   = 3'd4,
        SEL_STEP   = 3'd5,
        SEL_STATUS = 3'd6,
        SEL_COUNT  = 3'd7
    } reg_sel_e;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_TEN  = 1;
    localparam int CTRL_INIT = 2;

    localparam int ST_OS    = 0;
    localparam int ST_TG    = 1;
    localparam int ST_ARMED = 2;
endpackage

// File: rtl/tmr_mod_add.sv
// Modulo adder: sum = (a + b) mod (lim + 1).
// Assumes a <= lim and b <= lim, so that one subtraction is enough.
module tmr_mod_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] lim,
    output logic [W-1:0] sum
);
    logic [W:0] raw;
    logic [W:0] span;

    // Widened add, then fold back once past the period.
    always_comb begin
        raw  = {1'b0, a} + {1'b0, b};
        span = {1'b0, lim} + {{W{1'b0}}, 1'b1};
        if (raw >= span) begin
            sum = W'(raw - span);
        end else begin
            sum = raw[W-1:0];
        end
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Prescaler: a down counter that reloads from psc and yields one tick per (psc+1) clocks.
// Assumes a tick is wanted at once when run rises from reset (the down counter starts at 0).
module tmr_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] psc,
    output logic         tick
);
    logic [W-1:0] pcnt;

    assign tick = run && (pcnt == '0);

    // Count down while running and reload on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (run) begin
            if (pcnt == '0) begin
                pcnt <= psc;
            end else begin
                pcnt <= pcnt - 1'b1;
            end
        end
    end

    AST_PSC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc != '0) |=> !tick); // R2
endmodule

// File: rtl/tmr_counter.sv
// Shared up counter: advances on tick and wraps to 0 at or above the wrap value.
// cnt_nxt is the value the counter takes on the next tick; the channels compare against it.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    // Next value with wrap.
    always_comb begin
        cnt_nxt = (cnt >= reload) ? '0 : cnt + 1'b1;
    end

    // Take the next value on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_nxt;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt < reload) |=> cnt == W'($past(cnt) + 1'b1)); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt >= reload) |=> cnt == '0); // R3
endmodule

// File: rtl/tmr_oneshot.sv
// One-shot channel: a delay write arms it at (live count + delay) mod (reload+1).
// It fires once, when the counter takes that value, and then disarms.
// Assumes delay <= reload.
module tmr_oneshot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] reload,
    input  logic         arm_wr,
    input  logic [W-1:0] delay,
    output logic [W-1:0] cmp,
    output logic         armed,
    output logic         evt
);
    logic [W-1:0] target;
    logic         hit;

    tmr_mod_add #(.W(W)) u_target (
        .a   (cnt),
        .b   (delay),
        .lim (reload),
        .sum (target)
    );

    assign hit = tick && armed && (cnt_nxt == cmp);

    // Arm on a delay write, disarm on the match, and pulse the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp   <= '0;
            armed <= 1'b0;
            evt   <= 1'b0;
        end else begin
            evt <= hit;
            if (arm_wr) begin
                cmp   <= target;
                armed <= 1'b1;
            end else if (hit) begin
                armed <= 1'b0;
            end
        end
    end

    AST_OS_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !arm_wr) |=> (!armed && evt)); // R5
    AST_OS_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> cnt == $past(cmp)); // R4
endmodule

// File: rtl/tmr_toggle.sv
// Toggle channel: on each match it inverts the pin and adds the step to its compare value.
// While disabled, the pin follows the initial level. Assumes step <= reload.
module tmr_toggle #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] reload,
    input  logic         en,
    input  logic         init_lvl,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic [W-1:0] step,
    output logic [W-1:0] cmp,
    output logic         pin,
    output logic         evt
);
    logic [W-1:0] advanced;
    logic         hit;

    tmr_mod_add #(.W(W)) u_adv (
        .a   (cmp),
        .b   (step),
        .lim (reload),
        .sum (advanced)
    );

    assign hit = tick && en && (cnt_nxt == cmp);

    // Update the compare value, drive the pin level and pulse the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
            pin <= 1'b0;
            evt <= 1'b0;
        end else begin
            evt <= hit;
            if (cmp_wr) begin
                cmp <= cmp_wdata;
            end else if (hit) begin
                cmp <= advanced;
            end
            if (!en) begin
                pin <= init_lvl;
            end else if (hit) begin
                pin <= ~pin;
            end
        end
    end

    AST_TG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> pin != $past(pin)); // R6
    AST_TG_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> cnt == $past(cmp)); // R6
    AST_TG_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pin == $past(init_lvl)); // R7
endmodule

// File: rtl/dual_cmp_timer.sv
// Dual compare timer top: register file, sticky flags and read mux around a shared
// prescaled counter, a one-shot channel and a self-rearming toggle channel.
// Assumes CNT_W >= 3 and software keeps the delay and step at or below the wrap value.
module dual_cmp_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              os_evt,
    output logic              tg_evt,
    output logic              tg_pin
);
    localparam int PAD_W = CNT_W - 3;

    logic [2:0]       ctrl_q;
    logic [CNT_W-1:0] psc_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] step_q;
    logic             flag_os;
    logic             flag_tg;

    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] os_cmp;
    logic [CNT_W-1:0] tg_cmp;
    logic             os_armed;

    logic             wr_ctrl;
    logic             wr_psc;
    logic             wr_reload;
    logic             wr_delay;
    logic             wr_cmp2;
    logic             wr_step;
    logic             wr_status;
    logic             unused_wr_bits;

    assign wr_ctrl   = wr_en && (addr == SEL_CTRL);
    assign wr_psc    = wr_en && (addr == SEL_PSC);
    assign wr_reload = wr_en && (addr == SEL_RELOAD);
    assign wr_delay  = wr_en && (addr == SEL_DELAY);
    assign wr_cmp2   = wr_en && (addr == SEL_CMP2);
    assign wr_step   = wr_en && (addr == SEL_STEP);
    assign wr_status = wr_en && (addr == SEL_STATUS);
    assign unused_wr_bits = ^wr_data[CNT_W-1:3];

    // Holding registers for the control, prescaler, wrap and step fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            psc_q    <= '0;
            reload_q <= '1;
            step_q   <= '0;
        end else begin
            if (wr_ctrl)   ctrl_q   <= wr_data[2:0];
            if (wr_psc)    psc_q    <= wr_data;
            if (wr_reload) reload_q <= wr_data;
            if (wr_step)   step_q   <= wr_data;
        end
    end

    // Sticky event flags: set by events, cleared by writing 1; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_os <= 1'b0;
            flag_tg <= 1'b0;
        end else begin
            if (os_evt) begin
                flag_os <= 1'b1;
            end else if (wr_status && wr_data[ST_OS]) begin
                flag_os <= 1'b0;
            end
            if (tg_evt) begin
                flag_tg <= 1'b1;
            end else if (wr_status && wr_data[ST_TG]) begin
                flag_tg <= 1'b0;
            end
        end
    end

    // Read mux over the register selects.
    always_comb begin
        case (reg_sel_e'(addr))
            SEL_CTRL:   rd_data = {{PAD_W{1'b0}}, ctrl_q};
            SEL_PSC:    rd_data = psc_q;
            SEL_RELOAD: rd_data = reload_q;
            SEL_DELAY:  rd_data = os_cmp;
            SEL_CMP2:   rd_data = tg_cmp;
            SEL_STEP:   rd_data = step_q;
            SEL_STATUS: rd_data = {{PAD_W{1'b0}}, os_armed, flag_tg, flag_os};
            default:    rd_data = cnt;
        endcase
    end

    tmr_prescaler #(.W(CNT_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q[CTRL_RUN]),
        .psc   (psc_q),
        .tick  (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .reload  (reload_q),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    tmr_oneshot #(.W(CNT_W)) u_os (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .reload  (reload_q),
        .arm_wr  (wr_delay),
        .delay   (wr_data),
        .cmp     (os_cmp),
        .armed   (os_armed),
        .evt     (os_evt)
    );

    tmr_toggle #(.W(CNT_W)) u_tg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt       (cnt),
        .cnt_nxt   (cnt_nxt),
        .reload    (reload_q),
        .en        (ctrl_q[CTRL_TEN]),
        .init_lvl  (ctrl_q[CTRL_INIT]),
        .cmp_wr    (wr_cmp2),
        .cmp_wdata (wr_data),
        .step      (step_q),
        .cmp       (tg_cmp),
        .pin       (tg_pin),
        .evt       (tg_evt)
    );

    AST_OS_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        os_evt |=> flag_os); // R8
    AST_TG_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tg_evt |=> flag_tg); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_os && !(wr_status && wr_data[ST_OS])) |=> flag_os); // R8
endmodule

// File: tb/tb_dual_cmp_timer.sv
// Directed bench for dual_cmp_timer: one task per scenario, each checking its own results.
module tb_dual_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        os_evt;
    logic        tg_evt;
    logic        tg_pin;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_RELOAD = 3'd2, A_DELAY = 3'd3,
                           A_CMP2 = 3'd4, A_STEP = 3'd5, A_STATUS = 3'd6, A_COUNT = 3'd7;

    dual_cmp_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .os_evt  (os_evt),
        .tg_evt  (tg_evt),
        .tg_pin  (tg_pin)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        wr_en = 1'b0; addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_evt(input bit use_tg, input int maxc, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (use_tg ? tg_evt : os_evt) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(A_COUNT, v);  chk(v == 0, "R1 count", v, 0);
        rd(A_RELOAD, v); chk(v == 16'hFFFF, "R1 wrap", v, 16'hFFFF);
        rd(A_PSC, v);    chk(v == 0, "R1 prescaler", v, 0);
        rd(A_STATUS, v); chk(v == 0, "R1 status", v, 0);
        chk(tg_pin == 0 && os_evt == 0 && tg_evt == 0, "R1 outputs",
            {tg_pin, os_evt, tg_evt}, 0);
    endtask

    task automatic t_prescale();
        logic [15:0] c0, c1, c2;
        do_reset();
        wr(A_PSC, 16'd3);
        wr(A_CTRL, 16'd1);
        repeat (2) @(negedge clk);
        rd(A_COUNT, c0);
        repeat (4) @(negedge clk);
        rd(A_COUNT, c1);
        chk(c1 == c0 + 16'd1, "R2 one advance per 4 clocks", c1, c0 + 1);
        repeat (4) @(negedge clk);
        rd(A_COUNT, c2);
        chk(c2 == c0 + 16'd2, "R2 second window", c2, c0 + 2);
    endtask

    task automatic t_wrap();
        logic [15:0] prev, cur, a, b;
        int bad = 0;
        int wraps = 0;
        do_reset();
        wr(A_RELOAD, 16'd5);
        wr(A_CTRL, 16'd1);
        rd(A_COUNT, prev);
        for (int i = 0; i < 14; i++) begin
            logic [15:0] exp;
            @(negedge clk);
            rd(A_COUNT, cur);
            exp = (prev == 16'd5) ? 16'd0 : prev + 16'd1;
            if (cur != exp) begin
                bad++;
                chk(1'b0, "R3 count sequence", cur, exp);
            end
            if (cur == 0) wraps++;
            prev = cur;
        end
        chk(bad == 0, "R3 sequence clean", bad, 0);
        chk(wraps >= 2, "R3 wrapped to zero", wraps, 2);
        wr(A_CTRL, 16'd0);
        rd(A_COUNT, a);
        repeat (5) @(negedge clk);
        rd(A_COUNT, b);
        chk(a == b, "R3 halted while run is 0", b, a);
    endtask

    task automatic t_oneshot();
        logic [15:0] c, v;
        bit seen;
        int extra = 0;
        // Long wrap value, prescaler 2.
        do_reset();
        wr(A_PSC, 16'd2);
        wr(A_CTRL, 16'd1);
        repeat (30) @(negedge clk);
        wr(A_CTRL, 16'd0);
        rd(A_COUNT, c);
        wr(A_DELAY, 16'd7);
        wr(A_CTRL, 16'd1);
        wait_evt(1'b0, 200, seen);
        chk(seen, "R4 one-shot fired", seen, 1);
        rd(A_COUNT, v);
        chk(v == c + 16'd7, "R4 count at event", v, c + 16'd7);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (os_evt) extra++;
        end
        chk(extra == 0, "R5 no repeat after firing", extra, 0);
        // Short wrap value: target folds past the wrap.
        do_reset();
        wr(A_RELOAD, 16'd20);
        wr(A_CTRL, 16'd1);
        repeat (12) @(negedge clk);
        wr(A_CTRL, 16'd0);
        rd(A_COUNT, c);
        wr(A_DELAY, 16'd20);
        wr(A_CTRL, 16'd1);
        wait_evt(1'b0, 60, seen);
        chk(seen, "R4 wrapped one-shot fired", seen, 1);
        rd(A_COUNT, v);
        chk(v == (c + 16'd20) % 16'd21, "R4 wrapped target", v, (c + 20) % 21);
        extra = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (os_evt) extra++;
        end
        chk(extra == 0, "R5 disarmed across wraps", extra, 0);
        wr(A_CTRL, 16'd0);
        rd(A_COUNT, c);
        wr(A_DELAY, 16'd3);
        wr(A_CTRL, 16'd1);
        wait_evt(1'b0, 30, seen);
        rd(A_COUNT, v);
        chk(seen && v == (c + 16'd3) % 16'd21, "R5 re-armed by new delay", v, (c + 3) % 21);
    endtask

    task automatic t_flags();
        logic [15:0] v;
        rd(A_STATUS, v);
        chk(v[0] == 1'b1, "R8 one-shot flag set", v[0], 1);
        chk(v[1] == 1'b0, "R8 toggle flag untouched", v[1], 0);
        wr(A_STATUS, 16'd0);
        rd(A_STATUS, v);
        chk(v[0] == 1'b1, "R8 writing 0 keeps flag", v[0], 1);
        wr(A_STATUS, 16'd1);
        rd(A_STATUS, v);
        chk(v[0] == 1'b0, "R8 writing 1 clears flag", v[0], 0);
    endtask

    task automatic t_toggle();
        logic [15:0] v;
        bit seen;
        int exp_a[4] = '{10, 18, 26, 34};
        int exp_b[5] = '{16, 3, 11, 19, 6};
        do_reset();
        wr(A_STEP, 16'd8);
        wr(A_CMP2, 16'd10);
        wr(A_CTRL, 16'd3);
        for (int k = 0; k < 4; k++) begin
            wait_evt(1'b1, 50, seen);
            rd(A_COUNT, v);
            chk(seen && v == exp_a[k], "R6 match count", v, exp_a[k]);
            chk(tg_pin == ((k % 2) == 0), "R6 pin inverts", tg_pin, (k % 2) == 0);
        end
        rd(A_STATUS, v);
        chk(v[1] == 1'b1, "R8 toggle flag set", v[1], 1);
        do_reset();
        wr(A_RELOAD, 16'd20);
        wr(A_STEP, 16'd8);
        wr(A_CMP2, 16'd16);
        wr(A_CTRL, 16'd3);
        for (int k = 0; k < 5; k++) begin
            wait_evt(1'b1, 40, seen);
            rd(A_COUNT, v);
            chk(seen && v == exp_b[k], "R6 modulo advance", v, exp_b[k]);
            chk(tg_pin == ((k % 2) == 0), "R6 pin inverts after wrap", tg_pin, (k % 2) == 0);
        end
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        bit seen;
        int low_seen = 0;
        int evts = 0;
        do_reset();
        wr(A_RELOAD, 16'd20);
        wr(A_CMP2, 16'd5);
        wr(A_CTRL, 16'd5);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tg_pin != 1'b1) low_seen++;
            if (tg_evt) evts++;
        end
        chk(low_seen == 0, "R7 pin holds initial level", low_seen, 0);
        chk(evts == 0, "R7 no events while disabled", evts, 0);
        wr(A_CTRL, 16'd7);
        wait_evt(1'b1, 30, seen);
        rd(A_COUNT, v);
        chk(seen && v == 16'd5, "R7 first match at written compare", v, 5);
        chk(tg_pin == 1'b0, "R7 inverted from initial level", tg_pin, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_prescale();
        t_wrap();
        t_oneshot();
        t_flags();
        t_toggle();
        t_disabled();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule